// File: doc/BRIEF.md
# Flash Read Fault Status Register

This block keeps the sticky fault record for reads of a flash array. An ECC checker reports each read with two plain pulses, one for a corrected single-bit fault and one for an uncorrectable double-bit fault. These pulses count only in the cycle the array read strobe is high. The block also watches the command-busy line. A read that arrives while a flash command is running is an access collision. It is recorded by raising both fault flags together. A genuine ECC fault raises only one of them.

Software reaches the flags through a byte-wide register port. Reads are combinational from the address, and writes take one cycle. The fault flags and the command-error bits clear when a 1 is written to them. A companion enable register gates the two interrupt request outputs. A configuration input suppresses single-fault reporting. A separate status byte shows whether the controller is busy, together with two sticky command-error bits. All pins are plain control and status lines, so there is no stream interface and no back-pressure.

Top module: `flash_fault_stat`

## Requirements
- R1: After reset every register reads 0x00. At address 0, bits 7..2 always read 0. At address 1, bits 7..2 always read 0. At address 2, bits 6..2 always read 0.
- R2: A cycle with `rd_stb`=1, `cmd_busy`=0 and `ecc_dbl`=1 sets the double-fault flag (address 0, bit 1). It does not set the single-fault flag, even when `ecc_sgl` is also 1.
- R3: A cycle with `rd_stb`=1, `cmd_busy`=0, `ecc_sgl`=1 and `ecc_dbl`=0 sets the single-fault flag (address 0, bit 0) when `ign_sgl`=0. It sets nothing when `ign_sgl`=1.
- R4: A cycle with `rd_stb`=1 and `cmd_busy`=1 is a collision, whatever the ECC pulses are. A collision sets the double-fault flag, and also sets the single-fault flag when `ign_sgl`=0.
- R5: When `rd_stb`=0, the ECC pulses and `cmd_busy` set no fault flag.
- R6: A set flag stays set through later clean reads until software clears it.
- R7: A write to address 0 clears each flag whose data bit is 1. A data bit of 0 leaves its flag unchanged.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Address 1 holds the enables: bit 1 for double faults and bit 0 for single faults. The register is writable and reads back. `irq_dbl` equals flag bit 1 AND enable bit 1. `irq_sgl` equals flag bit 0 AND enable bit 0.
- R10: Address 2 bit 7 reads `cmd_busy` live. Bits 1..0 are sticky command-error bits. A pulse on `cmd_err_in[i]` sets bit i. Writing 1 to a bit clears it, and set wins over clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Array read issued this cycle |
| ecc_sgl | input | 1 | ECC single-bit fault corrected (pulse) |
| ecc_dbl | input | 1 | ECC double-bit fault (pulse) |
| cmd_busy | input | 1 | Flash command executing |
| ign_sgl | input | 1 | Suppress single-fault reporting |
| cmd_err_in | input | 2 | Command/reset error detected (pulses) |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_sgl | output | 1 | Single-fault interrupt request |
| irq_dbl | output | 1 | Double-fault interrupt request |

## Verification
The bench sweeps every combination of read strobe, busy, both ECC pulses and the ignore input, starting each time from cleared flags. A design that gave single faults priority, or that let a genuine fault raise both flags, would miss the double-only result. A design that dropped the collision encoding, or that let the ignore input mask the double flag, would show the wrong pair of bits. Clearing writes use every data pattern, which exposes a flag that clears on a zero bit. A set arriving in the same cycle as a clearing write exposes a design that gives priority to the clear. The interrupt enables are swept against every flag state, and the command-error and busy bits of the status byte are checked the same way.

// File: rtl/flash_fault_pkg.sv
package flash_fault_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int NFLAG  = 2;
  localparam int NERR   = 2;
  localparam int BIT_SGL  = 0;
  localparam int BIT_DBL  = 1;
  localparam int BIT_BUSY = 7;
  typedef enum logic [ADDR_W-1:0] {
    A_FAULT = 2'd0,
    A_EN    = 2'd1,
    A_STAT  = 2'd2,
    A_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import flash_fault_pkg::*;
(
  input  logic             rd_stb,
  input  logic             ecc_sgl,
  input  logic             ecc_dbl,
  input  logic             cmd_busy,
  input  logic             ign_sgl,
  output logic [NFLAG-1:0] set_vec
);
  logic collide, real_dbl, real_sgl;
  always_comb begin
    collide  = rd_stb & cmd_busy;
    real_dbl = rd_stb & ~cmd_busy & ecc_dbl;
    real_sgl = rd_stb & ~cmd_busy & ecc_sgl & ~ecc_dbl;
    set_vec  = '0;
    set_vec[BIT_DBL] = collide | real_dbl;
    set_vec[BIT_SGL] = ~ign_sgl & (collide | real_sgl);
  end
endmodule

// File: rtl/w1c_bank.sv
module w1c_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_fault_stat.sv
module flash_fault_stat
  import flash_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              ecc_sgl,
  input  logic              ecc_dbl,
  input  logic              cmd_busy,
  input  logic              ign_sgl,
  input  logic [NERR-1:0]   cmd_err_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_sgl,
  output logic              irq_dbl
);
  logic [NFLAG-1:0] fault_set, fault_clr, fault_q;
  logic [NERR-1:0]  err_clr, err_q;
  logic [NFLAG-1:0] en_q;

  fault_classify u_cls (
    .rd_stb  (rd_stb),
    .ecc_sgl (ecc_sgl),
    .ecc_dbl (ecc_dbl),
    .cmd_busy(cmd_busy),
    .ign_sgl (ign_sgl),
    .set_vec (fault_set)
  );

  assign fault_clr = (reg_wr && reg_addr == A_FAULT) ? reg_wdata[NFLAG-1:0] : '0;
  assign err_clr   = (reg_wr && reg_addr == A_STAT)  ? reg_wdata[NERR-1:0]  : '0;

  w1c_bank #(.W(NFLAG)) u_faults (
    .clk(clk), .rst_n(rst_n), .set_i(fault_set), .clr_i(fault_clr), .q(fault_q)
  );

  w1c_bank #(.W(NERR)) u_errs (
    .clk(clk), .rst_n(rst_n), .set_i(cmd_err_in), .clr_i(err_clr), .q(err_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          en_q <= '0;
    else if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[NFLAG-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FAULT: reg_rdata[NFLAG-1:0] = fault_q;
      A_EN:    reg_rdata[NFLAG-1:0] = en_q;
      A_STAT: begin
        reg_rdata[NERR-1:0] = err_q;
        reg_rdata[BIT_BUSY] = cmd_busy;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq_sgl = fault_q[BIT_SGL] & en_q[BIT_SGL];
  assign irq_dbl = fault_q[BIT_DBL] & en_q[BIT_DBL];
endmodule

// File: rtl/flash_fault_chk.sv
module flash_fault_chk
  import flash_fault_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              ecc_sgl,
  input logic              ecc_dbl,
  input logic              cmd_busy,
  input logic              ign_sgl,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq_sgl,
  input logic              irq_dbl
);
  logic pre_clr_sgl, pre_clr_dbl;
  assign pre_clr_sgl = reg_wr && reg_addr == A_FAULT && reg_wdata[BIT_SGL];
  assign pre_clr_dbl = reg_wr && reg_addr == A_FAULT && reg_wdata[BIT_DBL];

  // R4
  collide_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && cmd_busy |=> irq_dbl || !u_en_dbl_q);
  // R2
  dbl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !cmd_busy && ecc_dbl && !irq_sgl && !pre_clr_sgl |=> !irq_sgl);
  // R6
  sticky_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dbl && !pre_clr_dbl && !(reg_wr && reg_addr == A_EN) |=> irq_dbl);
  // R5
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb && !irq_dbl |=> !irq_dbl || $past(reg_wr && reg_addr == A_EN));
  // R10
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_STAT |-> reg_rdata[BIT_BUSY] == cmd_busy);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != A_STAT |-> reg_rdata[REG_W-1:NFLAG] == '0);

  logic u_en_dbl_q;
  always_ff @(posedge clk) begin
    if (!rst_n) u_en_dbl_q <= 1'b0;
    else if (reg_wr && reg_addr == A_EN) u_en_dbl_q <= reg_wdata[BIT_DBL];
  end
endmodule

bind flash_fault_stat flash_fault_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl),
  .cmd_busy(cmd_busy), .ign_sgl(ign_sgl), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
);

// File: tb/flash_fault_stat_tb.sv
module flash_fault_stat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_stb = 0, ecc_sgl = 0, ecc_dbl = 0, cmd_busy = 0, ign_sgl = 0;
  logic [1:0] cmd_err_in = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq_sgl, irq_dbl;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  flash_fault_stat dut_i (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl),
    .cmd_busy(cmd_busy), .ign_sgl(ign_sgl), .cmd_err_in(cmd_err_in),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_stb = 0; ecc_sgl = 0; ecc_dbl = 0; cmd_busy = 0; cmd_err_in = 0;
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wr = 1; reg_wdata = d; step();
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [1:0] ef;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], d);
      check("R1 reset", d, 8'h00);
    end
    // R2 R3 R4 R5 sweep
    for (int v = 0; v < 32; v++) begin
      logic r, b, s, db, ig;
      {r, b, s, db, ig} = v[4:0];
      ign_sgl = ig;
      rd_stb = r; cmd_busy = b; ecc_sgl = s; ecc_dbl = db;
      step();
      ef = 2'b00;
      if (r && b) ef = ig ? 2'b10 : 2'b11;
      else if (r && db) ef = 2'b10;
      else if (r && s && !ig) ef = 2'b01;
      rd_reg(2'd0, d);
      check(r ? (b ? "R4 collision" : (db ? "R2 double" : "R3 single")) : "R5 no read",
            d, {6'b0, ef});
      wr_reg(2'd0, 8'hFF);
    end
    ign_sgl = 0;
    // R6 sticky
    rd_stb = 1; ecc_dbl = 1; step();
    repeat (4) begin rd_stb = 1; step(); end
    rd_reg(2'd0, d); check("R6 sticky", d, 8'h02);
    // R7 W1C every pattern
    for (int p = 0; p < 4; p++) begin
      rd_stb = 1; cmd_busy = 1; step();
      wr_reg(2'd0, {6'b101010, p[1:0]});
      rd_reg(2'd0, d); check("R7 w1c", d, {6'b0, ~p[1:0]});
      wr_reg(2'd0, 8'h03);
    end
    // R8 set beats clear
    rd_stb = 1; ecc_sgl = 1; reg_addr = 0; reg_wr = 1; reg_wdata = 8'h01; step();
    rd_reg(2'd0, d); check("R8 set wins", d, 8'h01);
    wr_reg(2'd0, 8'h03);
    // R9 enables vs flags
    for (int f = 0; f < 4; f++) begin
      for (int e = 0; e < 4; e++) begin
        wr_reg(2'd0, 8'h03);
        rd_stb = f[1]; ecc_dbl = f[1]; step();
        rd_stb = f[0]; ecc_sgl = f[0]; step();
        wr_reg(2'd1, {6'b110011, e[1:0]});
        rd_reg(2'd1, d); check("R9 enable readback", d, {6'b0, e[1:0]});
        #1; check("R9 irq", {6'b0, irq_dbl, irq_sgl}, {6'b0, f[1:0] & e[1:0]});
      end
    end
    // R10 status register
    cmd_busy = 1; rd_reg(2'd2, d); check("R10 busy", d, 8'h80);
    cmd_busy = 0; rd_reg(2'd2, d); check("R10 idle", d, 8'h00);
    cmd_err_in = 2'b10; step();
    cmd_err_in = 2'b00; step();
    rd_reg(2'd2, d); check("R10 err sticky", d, 8'h02);
    cmd_err_in = 2'b01; reg_addr = 2; reg_wr = 1; reg_wdata = 8'h03; step();
    rd_reg(2'd2, d); check("R10 err set wins", d, 8'h01);
    wr_reg(2'd2, 8'h02);
    rd_reg(2'd2, d); check("R10 err w1c zero keeps", d, 8'h01);
    wr_reg(2'd2, 8'h01);
    rd_reg(2'd2, d); check("R10 err cleared", d, 8'h00);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule